// File: doc/BRIEF.md
# Shared-Bus Register Datapath

This block is the register-transfer half of a simple processor built around one internal bus. It contains eight general registers, a program counter, an instruction register, a memory address register, a memory data register, an operand staging register Y and an ALU result register Z. Every register has its own bus-drive enable and its own bus-load enable. The ALU takes the bus as its second operand. Its first operand is either Y or the constant 4, picked by a select bit. The result can only land in Z.

An external sequencer supplies one flat control word each cycle. The datapath has no decoding or step logic of its own. Because every move shares the one bus, a two-operand operation such as R3 = R1 + R2 takes three cycles: stage R1 in Y, put R2 on the bus and capture the sum in Z, then move Z into R3. The memory side presents MAR as the address and carries read and write strobes. MDR can be filled from the memory data input once the memory reports completion, or it can be filled from the bus so that its value can be written out.

Top module: `sbus_datapath`

## Requirements
- R1: `bus` equals the value of the one register whose drive enable is set, and is zero when no drive enable is set. Drive enable bit positions in `ctrl` are: general register k at bit k (0..7), PC at 16, IR at 18, MDR at 21, Z at 25.
- R2: A register whose load enable is set takes the `bus` value at the rising clock edge, and every other register holds its value. Load enable bit positions are: general register k at bit 8+k, PC at 17, IR at 19, MAR at 20, Y at 24. The `ir` port always shows IR.
- R3: `bus_conflict` is high in any cycle with two or more drive enables set, and low otherwise. During a conflict, `bus` carries the bitwise OR of the drivers.
- R4: The ALU's first operand is Y when bit 27 is 0 and the constant 4 when bit 27 is 1. Its second operand is `bus`. The function code sits in bits 30:28: 0 gives A+B, 1 gives A-B, 2 gives A AND B, 3 gives A OR B, 4 passes B, 5 gives A XOR B, 6 gives B shifted left by one, 7 passes A.
- R5: Z captures the ALU result only at an edge where bit 26 is set. Otherwise Z holds, and its value reaches `bus` only through its drive enable.
- R6: The three-cycle sequence (R1 drive, Y load), (R2 drive, first operand Y, add, Z load), (Z drive, R3 load) leaves R1+R2 in R3.
- R7: `mem_addr` shows MAR, which loads the low AW bits of `bus`. `mem_rd` follows bit 31 and `mem_wr` follows bit 32 in the same cycle.
- R8: MDR takes `mem_rdata` at an edge where bit 23 and `mem_mfc` are both high. With bit 23 set and `mem_mfc` low, MDR holds.
- R9: MDR loads `bus` at an edge where bit 22 is set. If the memory-side load of R8 happens at the same edge, the memory data wins.
- R10: `mem_wdata` carries MDR while `mem_wr` is high and is zero otherwise.
- R11: Reset clears every register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl | input | 2*NREG+17 | Control word for the current cycle |
| mem_rdata | input | DW | Data returned by memory |
| mem_mfc | input | 1 | Memory function complete |
| bus | output | DW | Internal bus value |
| ir | output | DW | Instruction register contents |
| mem_addr | output | AW | Memory address from MAR |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | DW | Write data from MDR |
| bus_conflict | output | 1 | Two or more bus drivers are active |

## Verification
Two pairs of actions can fall in the same cycle. In the first, Z drives the bus while it also loads, so the ALU consumes the old Z and Z takes the new result. In the second, MDR is asked to load from both the bus and memory at once. Random control words enable any subset of loads together with at most one driver. This produces both overlaps, along with register self-moves such as R1 driving while R1 loads. A bench model that applies the requirements to the pre-edge values judges every cycle through the bus and the memory ports. Directed steps force the MDR dual-load with completion both high and low, and they force a double drive to check the conflict flag.

// File: rtl/sbus_datapath.sv
module sbus_datapath #(
  parameter int DW = 32,
  parameter int AW = 16,
  parameter int NREG = 8,
  localparam int CW = 2*NREG + 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] ctrl,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_mfc,
  output logic [DW-1:0] bus,
  output logic [DW-1:0] ir,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  output logic          bus_conflict
);
  localparam int B_GOUT = 0;
  localparam int B_GIN  = NREG;
  localparam int B_PCO  = 2*NREG;
  localparam int B_PCI  = B_PCO + 1;
  localparam int B_IRO  = B_PCO + 2;
  localparam int B_IRI  = B_PCO + 3;
  localparam int B_MARI = B_PCO + 4;
  localparam int B_MDRO = B_PCO + 5;
  localparam int B_MDRI = B_PCO + 6;
  localparam int B_MDRE = B_PCO + 7;
  localparam int B_YI   = B_PCO + 8;
  localparam int B_ZO   = B_PCO + 9;
  localparam int B_ZI   = B_PCO + 10;
  localparam int B_S4   = B_PCO + 11;
  localparam int B_FN   = B_PCO + 12;
  localparam int B_RD   = B_PCO + 15;
  localparam int B_WR   = B_PCO + 16;
  localparam int NSRC   = NREG + 4;

  logic [DW-1:0] gpr [NREG];
  logic [DW-1:0] pc_q, ir_q, mdr_q, y_q, z_q;
  logic [AW-1:0] mar_q;
  logic [DW-1:0] src [NSRC];
  logic [NSRC-1:0] drv;
  logic [DW-1:0] bus_w, alu_a, alu_y;
  logic [2:0] fn;

  wire [NREG-1:0] g_in  = ctrl[B_GIN +: NREG];
  wire pc_in   = ctrl[B_PCI];
  wire ir_in   = ctrl[B_IRI];
  wire mar_in  = ctrl[B_MARI];
  wire mdr_in  = ctrl[B_MDRI];
  wire mdr_ine = ctrl[B_MDRE];
  wire y_in    = ctrl[B_YI];
  wire z_in    = ctrl[B_ZI];
  wire sel4    = ctrl[B_S4];

  assign fn  = ctrl[B_FN +: 3];
  assign drv = {ctrl[B_ZO], ctrl[B_MDRO], ctrl[B_IRO], ctrl[B_PCO], ctrl[B_GOUT +: NREG]};

  genvar gi;
  generate
    for (gi = 0; gi < NREG; gi++) begin : g_src
      assign src[gi] = gpr[gi];
    end
  endgenerate
  assign src[NREG]   = pc_q;
  assign src[NREG+1] = ir_q;
  assign src[NREG+2] = mdr_q;
  assign src[NREG+3] = z_q;

  always_comb begin
    bus_w = '0;
    for (int i = 0; i < NSRC; i++)
      if (drv[i]) bus_w = bus_w | src[i];
  end

  assign bus_conflict = (drv & (drv - NSRC'(1))) != '0;
  assign alu_a = sel4 ? DW'(4) : y_q;

  always_comb begin
    case (fn)
      3'd0: alu_y = alu_a + bus_w;
      3'd1: alu_y = alu_a - bus_w;
      3'd2: alu_y = alu_a & bus_w;
      3'd3: alu_y = alu_a | bus_w;
      3'd4: alu_y = bus_w;
      3'd5: alu_y = alu_a ^ bus_w;
      3'd6: alu_y = {bus_w[DW-2:0], 1'b0};
      default: alu_y = alu_a;
    endcase
  end

  generate
    for (gi = 0; gi < NREG; gi++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) gpr[gi] <= '0;
        else if (g_in[gi]) gpr[gi] <= bus_w;

      AST_GPR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        g_in[gi] |=> gpr[gi] == $past(bus_w)); // R2
      AST_GPR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !g_in[gi] |=> $stable(gpr[gi])); // R2
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0; ir_q <= '0; mar_q <= '0;
      mdr_q <= '0; y_q <= '0; z_q <= '0;
    end else begin
      if (pc_in)  pc_q  <= bus_w;
      if (ir_in)  ir_q  <= bus_w;
      if (mar_in) mar_q <= bus_w[AW-1:0];
      if (y_in)   y_q   <= bus_w;
      if (z_in)   z_q   <= alu_y;
      if (mdr_ine && mem_mfc) mdr_q <= mem_rdata;
      else if (mdr_in)        mdr_q <= bus_w;
    end
  end

  assign bus       = bus_w;
  assign ir        = ir_q;
  assign mem_addr  = mar_q;
  assign mem_rd    = ctrl[B_RD];
  assign mem_wr    = ctrl[B_WR];
  assign mem_wdata = mem_wr ? mdr_q : '0;

  AST_Z_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !z_in |=> $stable(z_q)); // R5
  AST_MAR_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    mar_in |=> mem_addr == $past(bus_w[AW-1:0])); // R7
  AST_MDR_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mdr_ine && !mem_mfc && !mdr_in) |=> $stable(mdr_q)); // R8
  AST_MDR_MEM_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (mdr_ine && mem_mfc) |=> mdr_q == $past(mem_rdata)); // R9
  AST_Z_ON_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (drv == NSRC'(1) << (NREG+3)) |-> bus == z_q); // R1
endmodule

// File: tb/sim_sbus_datapath.sv
module sim_sbus_datapath;
  localparam int DW = 32, AW = 16, NREG = 8, CW = 2*NREG + 17;
  localparam int PCO = 16, PCI = 17, IRO = 18, IRI = 19, MARI = 20, MDRO = 21,
                 MDRI = 22, MDRE = 23, YI = 24, ZO = 25, ZI = 26, S4 = 27,
                 FN = 28, RD = 31, WR = 32;

  logic clk = 0, rst_n = 0, mem_mfc = 0;
  logic [CW-1:0] ctrl = '0;
  logic [DW-1:0] mem_rdata = '0;
  logic [DW-1:0] bus, ir, mem_wdata;
  logic [AW-1:0] mem_addr;
  logic mem_rd, mem_wr, bus_conflict;
  int checks = 0, fails = 0;
  bit done = 0;

  logic [DW-1:0] m_gpr [NREG];
  logic [DW-1:0] m_pc, m_ir, m_mdr, m_y, m_z;
  logic [AW-1:0] m_mar;

  sbus_datapath #(.DW(DW), .AW(AW), .NREG(NREG)) u0 (
    .clk, .rst_n, .ctrl, .mem_rdata, .mem_mfc, .bus, .ir, .mem_addr,
    .mem_rd, .mem_wr, .mem_wdata, .bus_conflict);

  always #5 clk = ~clk;

  function automatic logic [DW-1:0] alu_ref(input logic [2:0] f, input logic [DW-1:0] a, b);
    case (f)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return b;
      3'd5: return a ^ b;
      3'd6: return b << 1;
      default: return a;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [CW-1:0] c, input logic [DW-1:0] rd, input logic mfc, input string tag);
    logic [DW-1:0] eb, nz;
    int n;
    @(negedge clk);
    ctrl = c; mem_rdata = rd; mem_mfc = mfc;
    #1;
    eb = '0; n = 0;
    for (int i = 0; i < NREG; i++) if (c[i]) begin eb |= m_gpr[i]; n++; end
    if (c[PCO])  begin eb |= m_pc;  n++; end
    if (c[IRO])  begin eb |= m_ir;  n++; end
    if (c[MDRO]) begin eb |= m_mdr; n++; end
    if (c[ZO])   begin eb |= m_z;   n++; end
    chk(bus == eb, tag, bus, eb);
    chk(bus_conflict == (n > 1), "R3", DW'(bus_conflict), DW'(n > 1));
    chk(mem_addr == m_mar && mem_rd == c[RD] && mem_wr == c[WR], "R7",
        DW'({mem_rd, mem_wr, mem_addr}), DW'({c[RD], c[WR], m_mar}));
    chk(mem_wdata == (c[WR] ? m_mdr : '0), "R10", mem_wdata, c[WR] ? m_mdr : '0);
    chk(ir == m_ir, "R2", ir, m_ir);
    nz = alu_ref(c[FN +: 3], c[S4] ? DW'(4) : m_y, eb);
    for (int i = 0; i < NREG; i++) if (c[NREG + i]) m_gpr[i] = eb;
    if (c[PCI])  m_pc  = eb;
    if (c[IRI])  m_ir  = eb;
    if (c[MARI]) m_mar = eb[AW-1:0];
    if (c[YI])   m_y   = eb;
    if (c[ZI])   m_z   = nz;
    if (c[MDRE] && mfc) m_mdr = rd;
    else if (c[MDRI])   m_mdr = eb;
  endtask

  function automatic logic [CW-1:0] bt(input int p);
    return CW'(1) << p;
  endfunction

  function automatic logic [CW-1:0] fnc(input int f);
    return CW'(f) << FN;
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] c;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NREG; i++) m_gpr[i] = '0;
    m_pc = '0; m_ir = '0; m_mdr = '0; m_y = '0; m_z = '0; m_mar = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    for (int i = 0; i < NREG; i++) step(bt(i), 0, 0, "R11");
    step(bt(PCO), 0, 0, "R11"); step(bt(IRO), 0, 0, "R11");
    step(bt(MDRO), 0, 0, "R11"); step(bt(ZO), 0, 0, "R11");

    step(bt(MDRE) | bt(RD), 32'd5, 1, "R8");
    step(bt(MDRO) | bt(NREG + 1), 0, 0, "R8");
    step(bt(MDRE) | bt(RD), 32'd7, 1, "R8");
    step(bt(MDRO) | bt(NREG + 2), 0, 0, "R8");
    step(bt(1) | bt(YI), 0, 0, "R6");
    step(bt(2) | fnc(0) | bt(ZI), 0, 0, "R6");
    step(bt(ZO) | bt(NREG + 3), 0, 0, "R6");
    step(bt(3), 0, 0, "R6");

    step(bt(MDRE), 32'd99, 0, "R8");
    step(bt(MDRO), 0, 0, "R8");
    step(bt(1) | bt(MDRI) | bt(MDRE), 32'hA5A5, 1, "R9");
    step(bt(MDRO), 0, 0, "R9");
    step(bt(2) | bt(MDRI) | bt(MDRE), 32'h1, 0, "R9");
    step(bt(MDRO) | bt(WR), 0, 0, "R9");

    step(bt(PCO) | bt(S4) | fnc(0) | bt(ZI), 0, 0, "R4");
    step(bt(ZO) | bt(PCI), 0, 0, "R5");
    step(bt(PCO) | bt(MARI) | bt(RD), 0, 0, "R4");
    step(bt(2) | bt(1), 0, 0, "R3");

    step(bt(MDRE), 32'hF0F0_1234, 1, "R8");
    step(bt(MDRO) | bt(YI) | bt(IRI), 0, 0, "R2");
    for (int f = 0; f < 8; f++) begin
      step(bt(1) | fnc(f) | bt(ZI), 0, 0, "R4");
      step(bt(ZO), 0, 0, "R4");
    end
    step(bt(ZO) | bt(2) | bt(ZI), 0, 0, "R3");
    step(bt(ZO) | bt(ZI) | fnc(0) | bt(S4), 0, 0, "R5");
    step(bt(ZO), 0, 0, "R5");

    for (int n = 0; n < 3000; n++) begin
      int k;
      c = '0;
      k = $urandom_range(0, 12);
      if (k < NREG) c[k] = 1;
      else if (k == 8)  c[PCO] = 1;
      else if (k == 9)  c[IRO] = 1;
      else if (k == 10) c[MDRO] = 1;
      else if (k == 11) c[ZO] = 1;
      for (int i = 0; i < NREG; i++) c[NREG + i] = ($urandom_range(0, 3) == 0);
      c[PCI] = ($urandom_range(0, 3) == 0);
      c[IRI] = ($urandom_range(0, 3) == 0);
      c[MARI] = ($urandom_range(0, 3) == 0);
      c[MDRI] = ($urandom_range(0, 3) == 0);
      c[MDRE] = ($urandom_range(0, 3) == 0);
      c[YI] = ($urandom_range(0, 2) == 0);
      c[ZI] = ($urandom_range(0, 1) == 0);
      c[S4] = $urandom_range(0, 1);
      c[FN +: 3] = 3'($urandom_range(0, 7));
      c[RD] = $urandom_range(0, 1);
      c[WR] = $urandom_range(0, 1);
      step(c, $urandom, $urandom_range(0, 1), "R1");
    end

    @(negedge clk);
    ctrl = '0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule